// File: doc/BRIEF.md
# Aperture Page Translation Unit

This block turns bus addresses that land in a remapping aperture into 40-bit physical addresses. An internal table of 32-bit page entries is indexed by the page number of the address relative to the aperture base. Each entry holds a physical page number whose upper eight bits are folded into the low part of the word, along with a valid flag and a coherent flag. Software programs the aperture through two configuration registers. One is a control register that holds the enable and a 3-bit size order. The other is a base register. Software loads entries through a table-write port.

A translation request is answered one clock later. The answer is either the physical address with the coherent flag, or a fault. The table keeps newly written entries from being used until a flush command publishes them. Software must therefore flush after every batch of table updates. A flush in the same cycle as a request wins, and that request is discarded.

Top module: `apt_xlate_unit`

## Requirements
- R1: After reset, both configuration registers read as zero, no response is valid, and every translation faults.
- R2: The aperture base is the 15-bit base field shifted left by 25. The aperture size is 32 MiB shifted left by control bits 3:1. An address is inside the aperture when base <= address < base + size, and its table index is (address - base) >> 12.
- R3: When base + size exceeds 4 GiB, the aperture is treated as absent and every translation faults.
- R4: A translation with control bit 0 (enable) clear, or with an address outside the aperture, faults. A faulting response has a physical address of zero and the coherent flag low.
- R5: For a usable entry, physical bits 39:32 come from entry bits 11:4. Physical bits 31:12 come from entry bits 31:12. Physical bits 11:0 are the request address bits 11:0. The coherent output equals entry bit 1.
- R6: An entry whose bit 0 (valid) is clear causes a fault.
- R7: An in-aperture address whose table index is at or above the table depth faults.
- R8: An entry that has never been written since reset faults. So does an entry written since the last flush. A flush makes all written entries usable.
- R9: rsp_valid is high exactly in the cycle after a cycle with req_valid high and flush low, and low otherwise.
- R10: When flush and req_valid are high in the same cycle, the flush takes effect and the request gets no response.
- R11: The control register keeps bits 5:0 of the written word. If the written word has bit 0 set, bits 5:4 are stored as zero. A register read returns the selected register (cfg_sel 0 control, 1 base) in the cycle after cfg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_rd | input | 1 | Configuration register read strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 base |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after cfg_rd |
| tbl_wr | input | 1 | Table entry write strobe |
| tbl_idx | input | 6 | Table entry index |
| tbl_data | input | 32 | Table entry contents |
| flush | input | 1 | Publish written entries; takes priority over a request |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_fault | output | 1 | Translation failed |
| rsp_coherent | output | 1 | Coherent flag of the entry used |
| rsp_paddr | output | 40 | Translated physical address |

## Verification
The bench loads every table entry with an arithmetic pattern and sweeps each page of the table, using a different in-page offset for each. A design that swapped the folded high bits, or did not carry the offset through, would return wrong addresses across the whole sweep. Entries are probed before the first flush and again after a rewrite. An unpublished entry that leaked through would return stale or unknown data where a fault is due. The bench also probes the edges of the aperture: one byte below the base, the first page past the table, and an aperture that ends exactly at 4 GiB next to one that crosses it. An off-by-one in the limit check would either reject the top aperture or accept the crossing one. Further checks cover a flush landing on the same cycle as a request, and a control write that sets enable together with bits 5:4.

// File: rtl/apt_pkg.sv
package apt_pkg;

  localparam int BUS_W      = 32;
  localparam int PA_W       = 40;
  localparam int ENT_W      = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int CTRL_W     = 6;

  typedef struct packed {
    logic [19:0] pa_mid;
    logic [7:0]  pa_hi;
    logic [1:0]  rsvd;
    logic        coh;
    logic        vld;
  } apt_entry_t;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_BASE = 1'b1
  } apt_sel_e;

  function automatic logic [PA_W-1:0] apt_entry_pa(apt_entry_t e,
                                                  logic [PAGE_SHIFT-1:0] off);
    return {e.pa_hi, e.pa_mid, off};
  endfunction

endpackage

// File: rtl/apt_cfg_regs.sv
module apt_cfg_regs
  import apt_pkg::*;
#(
  parameter int BASE_FIELD_W = 15,
  parameter int ORDER_W      = 3,
  parameter int SIZE_SHIFT   = 25,
  localparam int WIN_W       = BASE_FIELD_W + SIZE_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             win_en,
  output logic             win_present,
  output logic [WIN_W-1:0] win_base,
  output logic [WIN_W-1:0] win_size
);

  logic [CTRL_W-1:0]       ctrl_q;
  logic [BASE_FIELD_W-1:0] base_q;
  logic [ORDER_W-1:0]      order;
  logic [WIN_W-1:0]        win_end;
  logic [WIN_W-1:0]        bus_limit;
  logic                    unused_wdata;

  assign unused_wdata = ^cfg_wdata[31:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      base_q    <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_CTRL) begin
        ctrl_q <= cfg_wdata[CTRL_W-1:0];
        if (cfg_wdata[0]) ctrl_q[5:4] <= 2'b00;
      end
      if (cfg_wr && cfg_sel == SEL_BASE)
        base_q <= cfg_wdata[BASE_FIELD_W-1:0];
      if (cfg_rd)
        cfg_rdata <= (cfg_sel == SEL_CTRL) ? 32'(ctrl_q) : 32'(base_q);
    end
  end

  assign order       = ctrl_q[ORDER_W:1];
  assign win_en      = ctrl_q[0];
  assign win_base    = WIN_W'(base_q) << SIZE_SHIFT;
  assign win_size    = WIN_W'(1) << (SIZE_SHIFT + int'(order));
  assign win_end     = win_base + win_size;
  assign bus_limit   = WIN_W'(1) << BUS_W;
  assign win_present = (win_end <= bus_limit);

endmodule

// File: rtl/apt_window_check.sv
module apt_window_check
  import apt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIN_W = 41,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [BUS_W-1:0] addr,
  input  logic             en,
  input  logic             present,
  input  logic [WIN_W-1:0] base,
  input  logic [WIN_W-1:0] size,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [WIN_W-1:0] a_ext;
  logic [WIN_W-1:0] rel;
  logic [WIN_W-1:0] pg;
  logic             above_base;
  logic             below_end;
  logic             in_table;

  assign a_ext      = WIN_W'(addr);
  assign rel        = a_ext - base;
  assign pg         = rel >> PAGE_SHIFT;
  assign above_base = (a_ext >= base);
  assign below_end  = (a_ext < base + size);
  assign in_table   = (pg < WIN_W'(DEPTH));
  assign hit        = en && present && above_base && below_end && in_table;
  assign idx        = pg[IDX_W-1:0];

endmodule

// File: rtl/apt_entry_table.sv
module apt_entry_table
  import apt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             flush,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output apt_entry_t       rd_entry,
  output logic             rd_usable
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written_q;
  logic [DEPTH-1:0] pend_q;
  logic [DEPTH-1:0] pend_d;
  logic [ENT_W-1:0] rd_q;

  // storage: no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_entry = apt_entry_t'(rd_q);

  always_comb begin
    pend_d = flush ? '0 : pend_q;
    if (wr_en) pend_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      pend_q    <= '0;
      rd_usable <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (wr_en) written_q[wr_idx] <= 1'b1;
      if (rd_en) rd_usable <= written_q[rd_idx] && !pend_q[rd_idx];
    end
  end

endmodule

// File: rtl/apt_xlate_unit.sv
module apt_xlate_unit
  import apt_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int BASE_FIELD_W = 15,
  parameter int ORDER_W      = 3,
  parameter int SIZE_SHIFT   = 25,
  localparam int IDX_W       = $clog2(DEPTH),
  localparam int WIN_W       = BASE_FIELD_W + SIZE_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              tbl_wr,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [ENT_W-1:0]  tbl_data,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [BUS_W-1:0]  req_addr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_coherent,
  output logic [PA_W-1:0]   rsp_paddr
);

  logic             cfg_en;
  logic             cfg_present;
  logic [WIN_W-1:0] cfg_base;
  logic [WIN_W-1:0] cfg_size;
  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             take_req;
  apt_entry_t       ent;
  logic             ent_usable;
  logic             s_valid;
  logic             s_hit;
  logic [PAGE_SHIFT-1:0] s_off;
  logic             good;
  logic             unused_rsvd;

  assign take_req = req_valid && !flush;

  apt_cfg_regs #(
    .BASE_FIELD_W(BASE_FIELD_W), .ORDER_W(ORDER_W), .SIZE_SHIFT(SIZE_SHIFT)
  ) regs_i (
    .clk, .rst, .cfg_wr, .cfg_rd, .cfg_sel, .cfg_wdata, .cfg_rdata,
    .win_en(cfg_en), .win_present(cfg_present),
    .win_base(cfg_base), .win_size(cfg_size)
  );

  apt_window_check #(.DEPTH(DEPTH), .WIN_W(WIN_W)) win_i (
    .addr(req_addr), .en(cfg_en), .present(cfg_present),
    .base(cfg_base), .size(cfg_size), .hit(win_hit), .idx(win_idx)
  );

  apt_entry_table #(.DEPTH(DEPTH)) tbl_i (
    .clk, .rst, .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_data(tbl_data),
    .flush, .rd_en(take_req), .rd_idx(win_idx),
    .rd_entry(ent), .rd_usable(ent_usable)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_hit   <= 1'b0;
      s_off   <= '0;
    end else begin
      s_valid <= take_req;
      if (take_req) begin
        s_hit <= win_hit;
        s_off <= req_addr[PAGE_SHIFT-1:0];
      end
    end
  end

  assign unused_rsvd  = ^ent.rsvd;
  assign good         = s_valid && s_hit && ent_usable && ent.vld;
  assign rsp_valid    = s_valid;
  assign rsp_fault    = s_valid && !good;
  assign rsp_coherent = good && ent.coh;
  assign rsp_paddr    = good ? apt_entry_pa(ent, s_off) : '0;

endmodule

// File: rtl/apt_xlate_checker.sv
module apt_xlate_checker
  import apt_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            req_valid,
  input logic [BUS_W-1:0] req_addr,
  input logic            ctrl_en,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic            rsp_coherent,
  input logic [PA_W-1:0] rsp_paddr
);

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flush) |=> rsp_valid);

  assert_rsp_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !flush));

  assert_flush_drops_req_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && flush) |=> !rsp_valid);

  assert_fault_clean_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0 && !rsp_coherent));

  assert_disabled_faults_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flush && !ctrl_en) |=> rsp_fault);

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[PAGE_SHIFT-1:0] == $past(req_addr[PAGE_SHIFT-1:0]));

endmodule

bind apt_xlate_unit apt_xlate_checker chk_i (
  .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
  .req_addr(req_addr), .ctrl_en(cfg_en), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_coherent(rsp_coherent), .rsp_paddr(rsp_paddr)
);

// File: tb/apt_xlate_unit_tb.sv
module apt_xlate_unit_tb_top;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_rd = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tbl_wr = 0;
  logic [5:0]  tbl_idx = '0;
  logic [31:0] tbl_data = '0;
  logic        flush = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_fault, rsp_coherent;
  logic [39:0] rsp_paddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  apt_xlate_unit #(.DEPTH(DEPTH)) dut_i (
    .clk, .rst, .cfg_wr, .cfg_rd, .cfg_sel, .cfg_wdata, .cfg_rdata,
    .tbl_wr, .tbl_idx, .tbl_data, .flush, .req_valid, .req_addr,
    .rsp_valid, .rsp_fault, .rsp_coherent, .rsp_paddr
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    logic [19:0] mid;
    logic [7:0]  hi;
    mid = 20'((i * 4099 + 291 + salt * 7919) & 20'hfffff);
    hi  = 8'((i * 37 + 5 + salt) & 8'hff);
    return {mid, hi, 2'b00, i[0] ^ salt[0], 1'b1};
  endfunction

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic cfg_read(input bit sel, output logic [31:0] d);
    @(negedge clk); cfg_rd = 1; cfg_sel = sel;
    @(negedge clk); cfg_rd = 0; d = cfg_rdata;
  endtask

  task automatic tbl_write(input int i, input logic [31:0] d);
    @(negedge clk); tbl_wr = 1; tbl_idx = 6'(i); tbl_data = d;
    @(negedge clk); tbl_wr = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  // translate and compare; exp_ent valid only when !exp_fault
  task automatic xlate(input logic [31:0] a, input bit exp_fault,
                       input logic [31:0] exp_ent, input string tag);
    logic [39:0] exp_pa;
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
    exp_pa = exp_fault ? 40'h0 : {exp_ent[11:4], exp_ent[31:12], a[11:0]};
    chk(rsp_valid === 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_fault === exp_fault, {tag, " fault"}, 64'(rsp_fault), 64'(exp_fault));
    chk(rsp_paddr === exp_pa, {tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
    chk(rsp_coherent === (!exp_fault && exp_ent[1]), {tag, " coh"},
        64'(rsp_coherent), 64'(!exp_fault && exp_ent[1]));
    @(negedge clk);
    chk(rsp_valid === 1'b0, {tag, " R9 one-cycle"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic [31:0] base;
    logic [31:0] e;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    cfg_read(0, rd); chk(rd === 0, "R1 ctrl", 64'(rd), 0);
    cfg_read(1, rd); chk(rd === 0, "R1 base", 64'(rd), 0);
    xlate(32'h0000_1000, 1, 0, "R1 disabled");

    // R11 control write rules
    cfg_write(0, 32'hFFFF_FF35); cfg_read(0, rd);
    chk(rd === 32'h05, "R11 enable clears 5:4", 64'(rd), 64'h05);
    cfg_write(0, 32'h0000_0034); cfg_read(0, rd);
    chk(rd === 32'h34, "R11 disabled keeps 5:4", 64'(rd), 64'h34);
    // R4 enable clear
    xlate(32'h0000_0000, 1, 0, "R4 not enabled");

    // aperture: base field 16 -> 0x2000_0000, order 2 -> 128 MiB
    base = 32'h2000_0000;
    cfg_write(1, 32'hFFFF_8010); cfg_read(1, rd);
    chk(rd === 32'h0010, "R11 base field", 64'(rd), 64'h10);
    cfg_write(0, 32'h0000_0005);

    // R8 never written
    xlate(base, 1, 0, "R8 unwritten");

    for (int i = 0; i < DEPTH; i++) begin
      e = pat(i, 0);
      if (i % 5 == 3) e[0] = 1'b0;
      tbl_write(i, e);
    end
    // R8 written but not flushed
    xlate(base + 32'h2000, 1, 0, "R8 unflushed");
    do_flush();

    // R2 R5 R6 sweep
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] a;
      e = pat(i, 0);
      a = base + 32'(i) * 32'h1000 + 32'((i * 97 + 13) & 12'hfff);
      if (i % 5 == 3) xlate(a, 1, 0, "R6 invalid entry");
      else            xlate(a, 0, e, "R5 R2 sweep");
    end

    // R7 index past table, R4 below base
    xlate(base + 32'(DEPTH) * 32'h1000, 1, 0, "R7 past depth");
    xlate(base + 32'h0012_3456, 1, 0, "R7 far page");
    xlate(base - 32'd1, 1, 0, "R4 below base");
    xlate(base + 32'h0800_0000, 1, 0, "R4 past end");

    // R8 rewrite needs flush
    tbl_write(7, pat(7, 3));
    xlate(base + 32'h7abc, 1, 0, "R8 rewrite pending");
    do_flush();
    xlate(base + 32'h7abc, 0, pat(7, 3), "R8 rewrite published");

    // R10 flush with request
    @(negedge clk); flush = 1; req_valid = 1; req_addr = base;
    @(negedge clk); flush = 0; req_valid = 0;
    chk(rsp_valid === 1'b0, "R10 request dropped", 64'(rsp_valid), 0);
    xlate(base + 32'h0040, 0, pat(0, 0), "R10 after flush");

    // R3 aperture ending exactly at 4 GiB: base field 127, order 0
    cfg_write(1, 32'h0000_007F);
    cfg_write(0, 32'h0000_0001);
    xlate(32'hFE00_1010, 0, pat(1, 0), "R3 top aperture present");
    cfg_write(0, 32'h0000_0003);
    xlate(32'hFE00_1010, 1, 0, "R3 crosses 4GiB");
    cfg_write(1, 32'h0000_4000);
    cfg_write(0, 32'h0000_0001);
    xlate(32'h0000_1010, 1, 0, "R3 base above 4GiB");

    // R4 disable again
    cfg_write(1, 32'h0000_0010);
    cfg_write(0, 32'h0000_0004);
    xlate(base + 32'h1000, 1, 0, "R4 disabled after use");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule